// File: doc/BRIEF.md
# Unsigned Integer and Fractional Divider

This block is a sequential unsigned divider with two modes. Integer mode divides a 16-bit dividend by a 16-bit divisor and returns the whole quotient and the remainder. Fractional mode treats both operands as binary fractions with the radix point above the most significant bit. It returns the 16-bit fraction `(dividend * 2^16) / divisor` together with the matching remainder. In the surrounding processor the dividend comes from the D accumulator and the divisor from the X index register. The quotient is meant to go back to X and the remainder to D. That write-back sits outside this block.

A one-cycle `start` pulse captures the operands and the mode. The block then runs a restoring shift-and-subtract loop that produces one quotient bit per clock. After sixteen iterations it raises `done` for a single cycle and updates the result and flag outputs, which then hold until the next completion. Two exceptions replace the quotient with all ones and return the dividend unchanged as the remainder:
- a zero divisor, which sets the carry flag;
- a fractional request whose divisor does not exceed its dividend, which sets the overflow flag.

Top module: `udiv_top`

## Requirements
- R1: While reset is high and after it is released, busy, done, quotient, remainder and all three flags read 0 until the first completion.
- R2: With op_frac = 0 and a nonzero divisor, the completion shows quotient = dividend / divisor and remainder = dividend % divisor.
- R3: With op_frac = 1 and divisor > dividend, the completion shows quotient = (dividend * 65536) / divisor and remainder = (dividend * 65536) % divisor.
- R4: A zero divisor in either mode sets flag_carry to 1, forces the quotient to 16'hFFFF and returns the dividend as the remainder. flag_carry is 0 for any nonzero divisor.
- R5: With op_frac = 1 and divisor <= dividend, flag_ovf is 1, the quotient is 16'hFFFF and the remainder is the dividend. flag_ovf is 0 in integer mode and for every other fractional request.
- R6: At each completion flag_zero is 1 exactly when the reported quotient is 0.
- R7: A start seen at a rising edge while busy is low is accepted. busy is high from the next cycle. Results and a one-cycle done appear at the 16th rising edge after acceptance, and busy is low in the done cycle.
- R8: A start raised while busy is high is ignored. The running operation finishes with its own operands, and no extra operation follows.
- R9: Quotient, remainder and flags change only at a completion and hold their values in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a division; accepted only while busy is low |
| op_frac | input | 1 | 0 = integer divide, 1 = fractional divide |
| dividend_i | input | 16 | Dividend, captured with an accepted start |
| divisor_i | input | 16 | Divisor, captured with an accepted start |
| busy | output | 1 | High while the iteration loop runs |
| done | output | 1 | One-cycle pulse when results are updated |
| quotient | output | 16 | Quotient of the last completed operation |
| remainder | output | 16 | Remainder of the last completed operation |
| flag_zero | output | 1 | Quotient equals zero |
| flag_ovf | output | 1 | Fractional quotient does not fit |
| flag_carry | output | 1 | Divisor was zero |

## Verification
Every result of this block falls due at one fixed point: the 16th rising edge after the edge that accepts start. At that edge done rises and the quotient, remainder and flags take their new values together. busy, in contrast, is due one edge after acceptance. The bench model counts the same sixteen edges from the acceptance it sees on its own, holds the expected values in a queue, and releases them at that edge. The bench samples on falling edges and compares every output on every cycle, so a result that is early, late or not held shows up in the exact cycle where it goes wrong. Starts raised in the middle of a run and starts raised in the done cycle test where acceptance is refused and where it is allowed again.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

    // Operand and result width of the divider.
    localparam int DIV_W = 16;

    typedef enum logic {
        DIV_INT  = 1'b0,
        DIV_FRAC = 1'b1
    } div_mode_e;

    typedef struct packed {
        logic zero;
        logic ovf;
        logic carry;
    } div_flags_t;

    // True when the fractional quotient would need a bit above the radix point.
    function automatic logic frac_too_big(input div_mode_e mode,
                                          input logic [DIV_W-1:0] num,
                                          input logic [DIV_W-1:0] den);
        return (mode == DIV_FRAC) && (den <= num);
    endfunction

endpackage

// File: rtl/udiv_ctrl.sv
module udiv_ctrl #(
    parameter int WIDTH = udiv_pkg::DIV_W
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic finish
);
    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] iter_q;

    assign load   = start && !busy_q;
    assign finish = busy_q && (iter_q == LAST);
    assign busy   = busy_q;
    assign done   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            iter_q <= '0;
        end else begin
            done_q <= finish;
            if (load) begin
                busy_q <= 1'b1;
                iter_q <= '0;
            end else if (busy_q) begin
                iter_q <= iter_q + 1'b1;
                if (finish) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/udiv_iter.sv
module udiv_iter #(
    parameter int WIDTH = udiv_pkg::DIV_W
) (
    input  logic [WIDTH-1:0] part_rem,
    input  logic [WIDTH-1:0] part_quo,
    input  logic [WIDTH-1:0] dvsr,
    output logic [WIDTH-1:0] next_rem,
    output logic [WIDTH-1:0] next_quo
);
    // One restoring step: shift the next numerator bit into the partial
    // remainder, trial-subtract the divisor, keep the difference if no borrow.
    logic [WIDTH:0] shifted;
    logic [WIDTH:0] trial;
    logic           fits;

    assign shifted  = {part_rem, part_quo[WIDTH-1]};
    assign trial    = shifted - {1'b0, dvsr};
    assign fits     = !trial[WIDTH];
    assign next_rem = fits ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
    assign next_quo = {part_quo[WIDTH-2:0], fits};

endmodule

// File: rtl/udiv_datapath.sv
module udiv_datapath
    import udiv_pkg::*;
#(
    parameter int WIDTH = DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             finish,
    input  logic             op_frac,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output div_flags_t       flags
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    div_mode_e        mode;
    logic [WIDTH-1:0] rem_q, quo_q, dvsr_q, dvnd_q;
    logic [WIDTH-1:0] rem_n, quo_n;
    logic [WIDTH-1:0] quo_final, rem_final;
    logic             zdiv_q, ovf_q;
    logic             zdiv_in, ovf_in;
    logic [WIDTH-1:0] quo_r, rem_r;
    div_flags_t       flags_r;

    assign mode    = div_mode_e'(op_frac);
    assign zdiv_in = (divisor_i == '0);
    assign ovf_in  = frac_too_big(mode, dividend_i, divisor_i);

    udiv_iter #(.WIDTH(WIDTH)) u_iter (
        .part_rem (rem_q),
        .part_quo (quo_q),
        .dvsr     (dvsr_q),
        .next_rem (rem_n),
        .next_quo (quo_n)
    );

    // An exception replaces the loop result.
    assign quo_final = (zdiv_q || ovf_q) ? ALL_ONES : quo_n;
    assign rem_final = (zdiv_q || ovf_q) ? dvnd_q   : rem_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvsr_q <= '0;
            dvnd_q <= '0;
            zdiv_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else if (load) begin
            dvsr_q <= divisor_i;
            dvnd_q <= dividend_i;
            zdiv_q <= zdiv_in;
            ovf_q  <= ovf_in;
            // Integer: numerator is {0, dividend}; fractional: {dividend, 0}.
            if (mode == DIV_FRAC) begin
                rem_q <= dividend_i;
                quo_q <= '0;
            end else begin
                rem_q <= '0;
                quo_q <= dividend_i;
            end
        end else if (step) begin
            rem_q <= rem_n;
            quo_q <= quo_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_r   <= '0;
            rem_r   <= '0;
            flags_r <= '0;
        end else if (finish) begin
            quo_r         <= quo_final;
            rem_r         <= rem_final;
            flags_r.zero  <= (quo_final == '0);
            flags_r.ovf   <= ovf_q;
            flags_r.carry <= zdiv_q;
        end
    end

    assign quotient  = quo_r;
    assign remainder = rem_r;
    assign flags     = flags_r;

endmodule

// File: rtl/udiv_top.sv
module udiv_top
    import udiv_pkg::*;
#(
    parameter int WIDTH = DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             op_frac,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             flag_zero,
    output logic             flag_ovf,
    output logic             flag_carry
);
    logic       load, finish;
    div_flags_t flags;

    udiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .busy   (busy),
        .done   (done),
        .load   (load),
        .finish (finish)
    );

    udiv_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .step       (busy),
        .finish     (finish),
        .op_frac    (op_frac),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .quotient   (quotient),
        .remainder  (remainder),
        .flags      (flags)
    );

    assign flag_zero  = flags.zero;
    assign flag_ovf   = flags.ovf;
    assign flag_carry = flags.carry;

endmodule

// File: rtl/udiv_check.sv
module udiv_check #(
    parameter int WIDTH = udiv_pkg::DIV_W
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] quotient,
    input logic [WIDTH-1:0] remainder,
    input logic             flag_zero,
    input logic             flag_ovf,
    input logic             flag_carry
);
    // Length of the current busy run, checked against WIDTH at completion.
    int run_len;
    always_ff @(posedge clk) begin
        if (rst)       run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    assert_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_len == WIDTH));

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start && run_len < WIDTH - 1) |=> busy);

    assert_zero_div_R4: assert property (@(posedge clk) disable iff (rst)
        (done && flag_carry) |-> (quotient == '1));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (done && flag_ovf) |-> (quotient == '1));

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (flag_zero == (quotient == '0)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(flag_zero)
                   && $stable(flag_ovf) && $stable(flag_carry)));

endmodule

bind udiv_top udiv_check #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .quotient   (quotient),
    .remainder  (remainder),
    .flag_zero  (flag_zero),
    .flag_ovf   (flag_ovf),
    .flag_carry (flag_carry)
);

// File: tb/sim_udiv_top.sv
`timescale 1ns/1ps
module sim_udiv_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         op_frac = 1'b0;
    logic [W-1:0] dvd = '0;
    logic [W-1:0] dvs = '0;
    logic         busy, done, fz, fv, fc;
    logic [W-1:0] quo, rem;

    always #10 clk = ~clk;

    udiv_top u0 (
        .clk(clk), .rst(rst), .start(start), .op_frac(op_frac),
        .dividend_i(dvd), .divisor_i(dvs),
        .busy(busy), .done(done), .quotient(quo), .remainder(rem),
        .flag_zero(fz), .flag_ovf(fv), .flag_carry(fc)
    );

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        logic z, v, c;
        string tag;
    } exp_t;

    exp_t pend[$];

    // Behavioural reference: expected results from the requirements.
    function automatic exp_t predict(input logic [W-1:0] d, input logic [W-1:0] x,
                                     input logic f);
        exp_t e;
        longint n;
        e.c = (x == 0);                      // R4
        e.v = f && (x <= d);                 // R5
        if (e.c || e.v) begin
            e.q = '1;
            e.r = d;
            e.tag = e.c ? "R4" : "R5";
        end else begin
            n = f ? (longint'(d) * 65536) : longint'(d);
            e.q = W'(n / longint'(x));
            e.r = W'(n % longint'(x));
            e.tag = f ? "R3" : "R2";
        end
        e.z = (e.q == 0);                    // R6
        return e;
    endfunction

    bit           m_busy;
    int           m_cnt;
    logic         m_done;
    logic [W-1:0] m_q, m_r;
    logic         m_z, m_v, m_c;
    string        m_tag = "R1";

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_cnt = 0; m_done = 0;
            m_q = 0; m_r = 0; m_z = 0; m_v = 0; m_c = 0;
            m_tag = "R1";
            pend.delete();
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == W) begin : finish_op
                    exp_t e;
                    e = pend.pop_front();
                    m_q = e.q; m_r = e.r; m_z = e.z; m_v = e.v; m_c = e.c;
                    m_tag = e.tag;
                    m_busy = 0;
                    m_done = 1;
                end
            end else if (start) begin   // R8: start counts only while idle
                pend.push_back(predict(dvd, dvs, op_frac));
                m_busy = 1;
                m_cnt = 0;
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output on every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !ended) begin
            chk("R7", "busy", 32'(busy), 32'(m_busy));
            chk("R7", "done", 32'(done), 32'(m_done));
            chk(m_tag, "quotient (held per R9)", 32'(quo), 32'(m_q));
            chk(m_tag, "remainder (held per R9)", 32'(rem), 32'(m_r));
            chk("R6", "flag_zero", 32'(fz), 32'(m_z));
            chk("R5", "flag_ovf", 32'(fv), 32'(m_v));
            chk("R4", "flag_carry", 32'(fc), 32'(m_c));
        end
    end

    task automatic finish_run();
        ended = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Issue one operation; with now=1 start is raised in the current cycle.
    task automatic issue(input logic [W-1:0] d, input logic [W-1:0] x,
                         input logic f, input bit now);
        if (!now) @(negedge clk);
        dvd = d; dvs = x; op_frac = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end");
        finish_run();
    end

    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1", "busy in reset", 32'(busy), 0);
        chk("R1", "quotient in reset", 32'(quo), 0);
        chk("R1", "flags in reset", 32'({fz, fv, fc}), 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "done after reset", 32'(done), 0);
        chk("R1", "remainder after reset", 32'(rem), 0);

        // R2: integer divides
        issue(16'd1000, 16'd7, 1'b0, 0);
        chk("R2", "1000/7", 32'(quo), 32'd142);
        issue(16'hFFFF, 16'd1, 1'b0, 0);
        issue(16'd5, 16'd10, 1'b0, 0);
        chk("R6", "zero quotient flag", 32'(fz), 1);
        issue(16'hFFFF, 16'hFFFF, 1'b0, 0);
        chk("R5", "no ovf in integer mode", 32'(fv), 0);
        // R4: zero divisor in both modes
        issue(16'h1234, 16'd0, 1'b0, 0);
        chk("R4", "carry on /0", 32'(fc), 1);
        issue(16'd3, 16'd0, 1'b1, 0);
        chk("R4", "remainder on /0", 32'(rem), 32'd3);
        // R3: fractional divides
        issue(16'd1, 16'd2, 1'b1, 0);
        chk("R3", "1/2 fraction", 32'(quo), 32'h8000);
        issue(16'd1, 16'd3, 1'b1, 0);
        chk("R3", "1/3 fraction", 32'(quo), 32'd21845);
        issue(16'd0, 16'd5, 1'b1, 0);
        issue(16'hFFFE, 16'hFFFF, 1'b1, 0);
        // R5: fractional overflow at the equal boundary
        issue(16'd5, 16'd5, 1'b1, 0);
        chk("R5", "ovf when divisor equals dividend", 32'(fv), 1);
        // R7: start in the done cycle is accepted
        issue(16'd100, 16'd9, 1'b0, 1);
        chk("R7", "back-to-back 100/9", 32'(quo), 32'd11);

        // R8: start raised mid-run with other operands is ignored
        @(negedge clk);
        dvd = 16'd500; dvs = 16'd4; op_frac = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        dvd = 16'd7; dvs = 16'd0; op_frac = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);
        chk("R8", "first operands kept", 32'(quo), 32'd125);
        chk("R8", "no carry from ignored start", 32'(fc), 0);
        repeat (3) @(negedge clk);
        chk("R8", "no extra operation", 32'(busy), 0);

        // Mixed operands in both modes
        for (int i = 0; i < 60; i++) begin
            logic [15:0] a, b;
            lfsr = lfsr_next(lfsr); a = lfsr;
            lfsr = lfsr_next(lfsr); b = lfsr;
            if (i % 3 == 0) b = b >> (i % 11);
            if (i % 2 == 1 && a >= b) a = a >> 1;
            issue(a, b, 1'(i % 2), 0);
        end

        repeat (20) @(negedge clk);
        finish_run();
    end

endmodule